// File: doc/BRIEF.md
# Dual-Branch Packet Resolver

This block settles the control-flow outcome of one instruction packet that can carry up to two branch operations. Each branch slot arrives with a valid bit, a kind code, an already-evaluated predicate and a precomputed target. Slot 0 holds the branch at the lower address and slot 1 holds the one at the higher address. The block resolves the two slots in sequence rather than side by side. The earlier branch wins whenever it is taken. The later branch is acted on only when the earlier one falls through.

The block also checks legality. Some kinds may only appear as the later branch of a pair, and some may never be paired at all. A packet that closes a hardware loop may not carry any branch. For every valid packet the block registers four results: a taken flag, the next program counter, a link-register write with its return address, and an illegal flag. All of them appear one clock after the packet is presented. The next sequential address is the packet address plus a fixed step.

Top module: `branch_pair_resolver`

## Requirements
- R1: When both slots are valid and slot 0 is taken, the result is taken with slot 0's target, and slot 1 has no effect on any output.
- R2: When slot 0 is absent or not taken and slot 1 is taken, the result is taken with slot 1's target.
- R3: Kind codes are 0 direct jump, 1 conditional jump, 2 compare-and-jump, 3 call, 4 conditional call, 5 new-value compare jump, 6 indirect jump/call, 7 return with frame release. Kinds 1, 2, 4 and 5 are taken only when their predicate is 1. Kinds 0, 3, 6 and 7 are always taken.
- R4: With both slots valid, a slot-0 kind other than 1 or 2 raises the illegal flag.
- R5: With both slots valid, a slot-1 kind of 5, 6 or 7 raises the illegal flag. A single valid branch of any kind is legal.
- R6: A call (kind 3 or 4) in slot 1 that is ignored because slot 0 was taken does not assert the link write.
- R7: A performed call asserts the link write with the return address equal to the packet address plus STEP. Without a link write the return address output is zero.
- R8: A packet that has the loop-end input set and any valid branch raises the illegal flag.
- R9: An illegal packet, and a packet in which no branch is taken, give taken=0, no link write, and a next PC equal to the packet address plus STEP.
- R10: Results are registered and appear on the clock after the packet. With no valid packet, and after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_pc | input | AW | Packet address |
| loop_end | input | 1 | Packet closes a hardware loop |
| br0_valid | input | 1 | Lower-address branch present |
| br0_kind | input | 3 | Lower branch kind code |
| br0_pred | input | 1 | Lower branch predicate result |
| br0_target | input | AW | Lower branch target |
| br1_valid | input | 1 | Higher-address branch present |
| br1_kind | input | 3 | Higher branch kind code |
| br1_pred | input | 1 | Higher branch predicate result |
| br1_target | input | AW | Higher branch target |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | A branch was taken |
| res_next_pc | output | AW | Resolved next PC |
| res_link_we | output | 1 | Link register write enable |
| res_link_addr | output | AW | Return address to write |
| res_illegal | output | 1 | Illegal branch combination |

## Verification
On every cycle the assertions check several properties. A link write implies a taken branch. An illegal or not-taken result leaves the next PC at the sequential address with no link write. Every link write carries the packet address plus STEP. A loop-end packet with a branch is always flagged. Outputs stay quiet when no packet arrived. The bench scenarios are needed for the rest: which slot wins, per-kind predicate handling, the slot-position legality table, and the suppression of a call that sits behind a taken first branch.

// File: rtl/brres_pkg.sv
package brres_pkg;
    typedef enum logic [2:0] {
        K_JUMP   = 3'd0,
        K_CJUMP  = 3'd1,
        K_CMPJ   = 3'd2,
        K_CALL   = 3'd3,
        K_CCALL  = 3'd4,
        K_NVCMPJ = 3'd5,
        K_INDIR  = 3'd6,
        K_DEALLC = 3'd7
    } br_kind_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/branch_slot_eval.sv
module branch_slot_eval
    import brres_pkg::*;
#(
    parameter int POS = 0
) (
    input  logic     valid,
    input  br_kind_e kind,
    input  logic     pred,
    output logic     fires,
    output logic     is_call,
    output logic     pair_ok
);
    logic conditional;

    always_comb begin
        conditional = (kind == K_CJUMP) || (kind == K_CMPJ) ||
                      (kind == K_CCALL) || (kind == K_NVCMPJ);
        fires   = valid && (conditional ? pred : 1'b1);
        is_call = valid && ((kind == K_CALL) || (kind == K_CCALL));
    end

    generate
        if (POS == 0) begin : g_first
            // lower-address slot of a pair: only predicated plain/compare jumps
            assign pair_ok = (kind == K_CJUMP) || (kind == K_CMPJ);
        end else begin : g_second
            // higher-address slot: anything except unpairable kinds
            assign pair_ok = !((kind == K_NVCMPJ) || (kind == K_INDIR) ||
                               (kind == K_DEALLC));
        end
    endgenerate
endmodule

// File: rtl/branch_pick.sv
module branch_pick #(
    parameter int AW = 32
) (
    input  logic [1:0]    fires,
    input  logic [1:0]    calls,
    input  logic [AW-1:0] tgt0,
    input  logic [AW-1:0] tgt1,
    input  logic [AW-1:0] seq_pc,
    output logic          taken,
    output logic          call_do,
    output logic [AW-1:0] target
);
    always_comb begin
        taken   = 1'b0;
        call_do = 1'b0;
        target  = seq_pc;
        if (fires[0]) begin
            taken   = 1'b1;
            call_do = calls[0];
            target  = tgt0;
        end else if (fires[1]) begin
            taken   = 1'b1;
            call_do = calls[1];
            target  = tgt1;
        end
    end
endmodule

// File: rtl/branch_pair_resolver.sv
module branch_pair_resolver
    import brres_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_valid,
    input  logic [AW-1:0] pkt_pc,
    input  logic          loop_end,
    input  logic          br0_valid,
    input  logic [2:0]    br0_kind,
    input  logic          br0_pred,
    input  logic [AW-1:0] br0_target,
    input  logic          br1_valid,
    input  logic [2:0]    br1_kind,
    input  logic          br1_pred,
    input  logic [AW-1:0] br1_target,
    output logic          res_valid,
    output logic          res_taken,
    output logic [AW-1:0] res_next_pc,
    output logic          res_link_we,
    output logic [AW-1:0] res_link_addr,
    output logic          res_illegal
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    typedef struct packed {
        logic          valid;
        logic          taken;
        logic [AW-1:0] next_pc;
        logic          link_we;
        logic [AW-1:0] link_addr;
        logic          illegal;
    } res_t;

    res_t res_d, res_q;

    logic [NUM_SLOTS-1:0] vld, fires, calls, pair_ok;
    br_kind_e             kinds [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] preds;
    logic [AW-1:0]        seq_pc, pick_target;
    logic                 pick_taken, pick_call, dual, bad;

    assign vld      = {br1_valid, br0_valid};
    assign preds    = {br1_pred, br0_pred};
    assign kinds[0] = br_kind_e'(br0_kind);
    assign kinds[1] = br_kind_e'(br1_kind);
    assign seq_pc   = pkt_pc + STEP_W;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            branch_slot_eval #(.POS(g)) u_eval (
                .valid   (vld[g]),
                .kind    (kinds[g]),
                .pred    (preds[g]),
                .fires   (fires[g]),
                .is_call (calls[g]),
                .pair_ok (pair_ok[g])
            );
        end
    endgenerate

    branch_pick #(.AW(AW)) u_pick (
        .fires   (fires),
        .calls   (calls),
        .tgt0    (br0_target),
        .tgt1    (br1_target),
        .seq_pc  (seq_pc),
        .taken   (pick_taken),
        .call_do (pick_call),
        .target  (pick_target)
    );

    always_comb begin
        dual  = vld[0] && vld[1];
        bad   = (dual && !(&pair_ok)) || (loop_end && (|vld));
        res_d = '0;
        if (pkt_valid) begin
            res_d.valid   = 1'b1;
            res_d.illegal = bad;
            res_d.next_pc = seq_pc;
            if (!bad) begin
                res_d.taken     = pick_taken;
                res_d.next_pc   = pick_target;
                res_d.link_we   = pick_call;
                res_d.link_addr = pick_call ? seq_pc : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid     = res_q.valid;
    assign res_taken     = res_q.taken;
    assign res_next_pc   = res_q.next_pc;
    assign res_link_we   = res_q.link_we;
    assign res_link_addr = res_q.link_addr;
    assign res_illegal   = res_q.illegal;

    p_link_needs_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> res_taken);

    p_link_addr_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_link_we |-> res_link_addr == $past(pkt_pc) + STEP_W);

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_illegal |->
            !res_taken && !res_link_we && res_next_pc == $past(pkt_pc) + STEP_W);

    p_fallthrough_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_taken |-> res_next_pc == $past(pkt_pc) + STEP_W);

    p_loop_end_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(loop_end && (br0_valid || br1_valid)) |-> res_illegal);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_taken && !res_link_we && !res_illegal);
endmodule

// File: tb/test_branch_pair_resolver.sv
module test_branch_pair_resolver;
    localparam int AW = 32;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_valid = 1'b0, loop_end = 1'b0;
    logic [AW-1:0] pkt_pc = '0;
    logic          br0_valid = 1'b0, br0_pred = 1'b0;
    logic [2:0]    br0_kind = '0;
    logic [AW-1:0] br0_target = '0;
    logic          br1_valid = 1'b0, br1_pred = 1'b0;
    logic [2:0]    br1_kind = '0;
    logic [AW-1:0] br1_target = '0;
    logic          res_valid, res_taken, res_link_we, res_illegal;
    logic [AW-1:0] res_next_pc, res_link_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    branch_pair_resolver #(.AW(AW), .STEP(STEP)) i_branch_pair_resolver (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_pc(pkt_pc),
        .loop_end(loop_end),
        .br0_valid(br0_valid), .br0_kind(br0_kind), .br0_pred(br0_pred),
        .br0_target(br0_target),
        .br1_valid(br1_valid), .br1_kind(br1_kind), .br1_pred(br1_pred),
        .br1_target(br1_target),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .res_link_we(res_link_we), .res_link_addr(res_link_addr),
        .res_illegal(res_illegal)
    );

    function automatic logic is_cond(input logic [2:0] k);
        return (k == 3'd1) || (k == 3'd2) || (k == 3'd4) || (k == 3'd5);
    endfunction

    function automatic logic is_callk(input logic [2:0] k);
        return (k == 3'd3) || (k == 3'd4);
    endfunction

    // packed expectation: {valid, taken, next_pc, link_we, link_addr, illegal}
    function automatic logic [2*AW+3:0] model(
        input logic pv, input logic [AW-1:0] pc, input logic le,
        input logic v0, input logic [2:0] k0, input logic p0, input logic [AW-1:0] t0,
        input logic v1, input logic [2:0] k1, input logic p1, input logic [AW-1:0] t1);
        logic [AW-1:0] seq, npc, la;
        logic tk, we, ill, f0, f1;
        seq = pc + AW'(STEP);
        if (!pv) return '0;
        ill = (le && (v0 || v1)) ||
              (v0 && v1 && (!(k0 == 3'd1 || k0 == 3'd2) || k1 >= 3'd5));
        f0 = v0 && (!is_cond(k0) || p0);
        f1 = v1 && (!is_cond(k1) || p1);
        tk = 1'b0; we = 1'b0; la = '0; npc = seq;
        if (!ill) begin
            if (f0) begin
                tk = 1'b1; npc = t0; we = is_callk(k0);
            end else if (f1) begin
                tk = 1'b1; npc = t1; we = is_callk(k1);
            end
            if (we) la = seq;
        end
        return {1'b1, tk, npc, we, la, ill};
    endfunction

    task automatic apply(input string req,
        input logic pv, input logic [AW-1:0] pc, input logic le,
        input logic v0, input logic [2:0] k0, input logic p0, input logic [AW-1:0] t0,
        input logic v1, input logic [2:0] k1, input logic p1, input logic [AW-1:0] t1);
        logic [2*AW+3:0] exp_v, act_v;
        @(negedge clk);
        pkt_valid = pv; pkt_pc = pc; loop_end = le;
        br0_valid = v0; br0_kind = k0; br0_pred = p0; br0_target = t0;
        br1_valid = v1; br1_kind = k1; br1_pred = p1; br1_target = t1;
        exp_v = model(pv, pc, le, v0, k0, p0, t0, v1, k1, p1, t1);
        @(posedge clk);
        @(negedge clk);
        act_v = {res_valid, res_taken, res_next_pc, res_link_we, res_link_addr, res_illegal};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
        pkt_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] a_pc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if ({res_valid, res_taken, res_link_we, res_illegal} !== 4'b0) begin
            n_fail++;
            $display("FAIL R10 reset: actual %b expected 0000",
                     {res_valid, res_taken, res_link_we, res_illegal});
        end
        rst_n = 1'b1;
        a_pc = 32'h0000_1000;
        // R10 idle
        apply("R10", 0, a_pc, 0, 1, 3'd0, 0, 32'h10, 0, 3'd0, 0, 0);
        // R1 first taken wins, R6 call behind suppressed
        apply("R1",  1, a_pc, 0, 1, 3'd1, 1, 32'h200, 1, 3'd0, 0, 32'h300);
        apply("R6",  1, a_pc, 0, 1, 3'd2, 1, 32'h204, 1, 3'd3, 0, 32'h304);
        apply("R6",  1, a_pc, 0, 1, 3'd1, 1, 32'h208, 1, 3'd4, 1, 32'h308);
        // R2 second performed
        apply("R2",  1, a_pc, 0, 1, 3'd1, 0, 32'h200, 1, 3'd0, 0, 32'h300);
        apply("R7",  1, a_pc, 0, 1, 3'd2, 0, 32'h200, 1, 3'd3, 0, 32'h340);
        apply("R7",  1, 32'hFFFF_FFFC, 0, 0, 3'd0, 0, 0, 1, 3'd4, 1, 32'h80);
        // R3 predicate handling
        apply("R3",  1, a_pc, 0, 1, 3'd5, 0, 32'h500, 0, 3'd0, 0, 0);
        apply("R3",  1, a_pc, 0, 1, 3'd6, 0, 32'h600, 0, 3'd0, 0, 0);
        apply("R3",  1, a_pc, 0, 0, 3'd0, 0, 0, 1, 3'd4, 0, 32'h700);
        // R4 slot-0 legality
        apply("R4",  1, a_pc, 0, 1, 3'd0, 1, 32'h200, 1, 3'd1, 1, 32'h300);
        apply("R4",  1, a_pc, 0, 1, 3'd3, 1, 32'h200, 1, 3'd1, 1, 32'h300);
        // R5 unpairable kinds, and single-branch legality
        apply("R5",  1, a_pc, 0, 1, 3'd1, 0, 32'h200, 1, 3'd6, 1, 32'h300);
        apply("R5",  1, a_pc, 0, 1, 3'd2, 0, 32'h200, 1, 3'd7, 1, 32'h300);
        apply("R5",  1, a_pc, 0, 0, 3'd0, 0, 0, 1, 3'd7, 0, 32'h900);
        // R8 loop end
        apply("R8",  1, a_pc, 1, 0, 3'd0, 0, 0, 1, 3'd1, 1, 32'h300);
        apply("R8",  1, a_pc, 1, 0, 3'd0, 0, 0, 0, 3'd0, 0, 0);
        // R9 nothing taken
        apply("R9",  1, a_pc, 0, 1, 3'd1, 0, 32'h200, 1, 3'd2, 0, 32'h300);
        apply("R9",  1, a_pc, 0, 0, 3'd0, 0, 0, 0, 3'd0, 0, 0);
        // random mix (R1 R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 400; i++) begin
            logic [2:0] k0r, k1r;
            k0r = 3'($urandom_range(0, 7));
            k1r = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0) k0r = 3'($urandom_range(1, 2));
            apply("random R1-mix",
                  ($urandom_range(0, 7) != 0), $urandom & 32'hFFFF_FFFC,
                  ($urandom_range(0, 9) == 0),
                  1'($urandom), k0r, 1'($urandom), $urandom,
                  1'($urandom), k1r, 1'($urandom), $urandom);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule